// File: doc/BRIEF.md
# Power Partition Bring-Up Sequencer

This block runs the ordered power-up and power-down sequences of one switchable power partition. On a power-up command it requests power, waits for the power-good indication, and then walks the partition through reset, clock enable, isolation clamp release, reset release and the end of its memory-traffic flush. Between steps it holds fixed, timed waits. On a power-down command it places the partition in reset, confirms that no clock of the partition is still held on by a client, flushes the partition's memory traffic, re-engages the clamps and drops the power request.

The partition has up to four clock/reset slots. A per-slot type input says whether a slot takes part in clocking, in reset, or in both. If an up command finds the partition already powered, the sequencer only pulses its resets with the clocks briefly running. The sequencer reports success with a one-cycle done pulse. It reports failure with a one-cycle error pulse in three cases: power never arrives, power is lost part way through, or a clock is still enabled at power-down. A command that arrives while a sequence is running is dropped.

Top module: `pwr_part_seq`

## Requirements
- R1: From power-off, an up command raises `pwr_req` on the next cycle. Once `pwr_good` is seen, resets are asserted and clocks enabled while the clamp is held. `iso_clamp` drops exactly WAIT_CYC cycles after the clocks turn on, and `rst_out` clears exactly WAIT_CYC cycles after that. `flush_req` clears one cycle later. One cycle after that the clocks turn off and `done` pulses. WAIT_CYC is CLK_MHZ*WAIT_US.
- R2: Each slot has a 2-bit type field in `slot_type[2i+1:2i]`. The codes are: 00 unused, 01 clock and reset, 10 reset only, 11 clock only. A slot's clock is enabled only for codes 01 and 11, and its reset is driven only for codes 01 and 10.
- R3: An up command while `pwr_req` is high runs only a reset pulse. Resets assert on the next cycle. Clocks turn on WAIT_CYC cycles later, and resets release WAIT_CYC cycles after that. Clocks turn off with `done` one cycle later. `pwr_req` stays high and `iso_clamp` stays low throughout.
- R4: A down command on a powered partition asserts resets on the next cycle and raises `flush_req` the cycle after. Once `flush_ack` is high it raises `iso_clamp` on the next cycle. One cycle later it drops `pwr_req` together with `done`.
- R5: A down command is refused if `ext_clk_on` is set on any slot whose type carries a clock. In that case `err` pulses two cycles after the command, resets are released again, and power and clamp are left as they were. Bits of `ext_clk_on` on reset-only or unused slots are ignored.
- R6: If `pwr_good` does not arrive, `err` pulses PG_TIMEOUT+1 cycles after the up command, with `pwr_req` low and `iso_clamp` high.
- R7: If `pwr_good` is lost after the partition has started coming up, the steps are undone in reverse order. Clocks go off with resets and flush re-asserted, then the clamp re-engages, then `pwr_req` drops with an `err` pulse.
- R8: A command presented while `busy` is high has no effect on the running sequence or on the state after it.
- R9: `done` and `err` are single-cycle pulses and are never high together. A down command on an unpowered partition answers with `done` on the next cycle and changes nothing else.
- R10: After reset the partition is unpowered: `pwr_req` low, `iso_clamp` high, `flush_req` high, every reset-capable slot held in reset, all clocks off, `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled only when idle |
| cmd_up | input | 1 | 1 = power up, 0 = power down |
| pwr_good | input | 1 | Power switch reports the rail is up |
| flush_ack | input | 1 | Memory flush has drained |
| slot_type | input | 2*NSLOT | Per-slot type codes |
| ext_clk_on | input | NSLOT | Clocks currently held on by clients, per slot |
| pwr_req | output | 1 | Power-on request to the switch |
| rst_out | output | NSLOT | Per-slot reset, active high |
| clk_en | output | NSLOT | Per-slot clock enable |
| iso_clamp | output | 1 | Output isolation clamp, active high |
| flush_req | output | 1 | Memory flush request, active high |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |

## Verification
A wrong state or a stuck wait shows at the ports as a shifted step. For example, the clamp may release off the WAIT_CYC grid, or the reset may release before the clamp. The bench catches these by timing each output edge against the command and against the previous edge. A state that skips the flush handshake drops `pwr_req` while `flush_ack` is still low, which shows within the same down sequence. A decode fault in a slot shows as a mismatch of `clk_en` or `rst_out` against the type codes on the first cycle the clocks or resets are driven.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic [1:0] {
      SLOT_NONE     = 2'b00,
      SLOT_CLK_RST  = 2'b01,
      SLOT_RST_ONLY = 2'b10,
      SLOT_CLK_ONLY = 2'b11
   } slot_kind_e;

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_PG_WAIT,
      ST_UP_CLK,
      ST_UP_W1,
      ST_UP_W2,
      ST_UP_FLUSH,
      ST_UP_COFF,
      ST_PL_W1,
      ST_PL_W2,
      ST_PL_COFF,
      ST_DN_CHK,
      ST_DN_FLUSH,
      ST_DN_OFF,
      ST_UN_CLK,
      ST_UN_CLAMP,
      ST_UN_PWR
   } seq_state_e;

   function automatic logic kind_has_clk(input slot_kind_e k);
      return (k == SLOT_CLK_RST) || (k == SLOT_CLK_ONLY);
   endfunction

   function automatic logic kind_has_rst(input slot_kind_e k);
      return (k == SLOT_CLK_RST) || (k == SLOT_RST_ONLY);
   endfunction

endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
   parameter int LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic fire
);
   localparam int CW = $clog2(LEN + 1);

   if (LEN < 1) begin : g_bad_len
      $error("pps_timer: LEN must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          run;

   assign fire = run && (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (start) begin
         cnt <= CW'(LEN);
         run <= 1'b1;
      end else if (run) begin
         if (cnt == CW'(1)) run <= 1'b0;
         else               cnt <= cnt - CW'(1);
      end
   end
endmodule

// File: rtl/pps_slot_map.sv
module pps_slot_map
   import pps_pkg::*;
#(
   parameter int NSLOT = 4
) (
   input  logic [2*NSLOT-1:0] slot_type,
   input  logic               rst_hold,
   input  logic               clk_hold,
   output logic [NSLOT-1:0]   rst_out,
   output logic [NSLOT-1:0]   clk_en,
   output logic [NSLOT-1:0]   clk_cap
);
   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      slot_kind_e kind;
      logic       rst_cap;
      assign kind       = slot_kind_e'(slot_type[2*g +: 2]);
      assign clk_cap[g] = kind_has_clk(kind);
      assign rst_cap    = kind_has_rst(kind);
      assign rst_out[g] = rst_hold & rst_cap;
      assign clk_en[g]  = clk_hold & clk_cap[g];
   end
endmodule

// File: rtl/pwr_part_seq.sv
module pwr_part_seq
   import pps_pkg::*;
#(
   parameter int NSLOT      = 4,
   parameter int CLK_MHZ    = 100,
   parameter int WAIT_US    = 10,
   parameter int PG_TIMEOUT = 5000,
   parameter bit SYNC_IN    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic               cmd_up,
   input  logic               pwr_good,
   input  logic               flush_ack,
   input  logic [2*NSLOT-1:0] slot_type,
   input  logic [NSLOT-1:0]   ext_clk_on,
   output logic               pwr_req,
   output logic [NSLOT-1:0]   rst_out,
   output logic [NSLOT-1:0]   clk_en,
   output logic               iso_clamp,
   output logic               flush_req,
   output logic               busy,
   output logic               done,
   output logic               err
);
   localparam int WAIT_CYC = CLK_MHZ * WAIT_US;

   if (NSLOT < 1 || NSLOT > 4) begin : g_bad_nslot
      $error("pwr_part_seq: NSLOT must be 1 to 4");
   end
   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("pwr_part_seq: settle wait must be at least one cycle");
   end
   if (PG_TIMEOUT < 2) begin : g_bad_pgto
      $error("pwr_part_seq: PG_TIMEOUT must be at least 2");
   end

   // Input conditioning: direct or two-flop synchronised
   logic pg_s, fa_s;
   if (SYNC_IN) begin : g_sync
      logic [1:0] pg_q, fa_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pg_q <= '0;
            fa_q <= '0;
         end else begin
            pg_q <= {pg_q[0], pwr_good};
            fa_q <= {fa_q[0], flush_ack};
         end
      end
      assign pg_s = pg_q[1];
      assign fa_s = fa_q[1];
   end else begin : g_direct
      assign pg_s = pwr_good;
      assign fa_s = flush_ack;
   end

   seq_state_e       state;
   logic             rst_hold, clk_hold;
   logic [NSLOT-1:0] clk_cap;
   logic             wait_start, wait_fire;
   logic             pg_start, pg_fire;
   logic             take_up, take_dn;

   assign busy    = (state != ST_IDLE);
   assign take_up = (state == ST_IDLE) && cmd_valid && cmd_up;
   assign take_dn = (state == ST_IDLE) && cmd_valid && !cmd_up;

   always_comb begin
      wait_start = 1'b0;
      case (state)
         ST_IDLE:  wait_start = take_up && pwr_req;
         ST_UP_CLK: wait_start = pg_s;
         ST_UP_W1: wait_start = pg_s && wait_fire;
         ST_PL_W1: wait_start = wait_fire;
         default:  wait_start = 1'b0;
      endcase
      pg_start = take_up && !pwr_req;
   end

   pps_timer #(.LEN(WAIT_CYC)) i_wait_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wait_start),
      .fire  (wait_fire)
   );

   pps_timer #(.LEN(PG_TIMEOUT)) i_pg_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (pg_start),
      .fire  (pg_fire)
   );

   pps_slot_map #(.NSLOT(NSLOT)) i_slot_map (
      .slot_type (slot_type),
      .rst_hold  (rst_hold),
      .clk_hold  (clk_hold),
      .rst_out   (rst_out),
      .clk_en    (clk_en),
      .clk_cap   (clk_cap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pwr_req   <= 1'b0;
         rst_hold  <= 1'b1;
         clk_hold  <= 1'b0;
         iso_clamp <= 1'b1;
         flush_req <= 1'b1;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (take_up) begin
                  if (pwr_req) begin
                     rst_hold <= 1'b1;
                     state    <= ST_PL_W1;
                  end else begin
                     pwr_req <= 1'b1;
                     state   <= ST_PG_WAIT;
                  end
               end else if (take_dn) begin
                  if (pwr_req) begin
                     rst_hold <= 1'b1;
                     state    <= ST_DN_CHK;
                  end else begin
                     done <= 1'b1;
                  end
               end
            end
            ST_PG_WAIT: begin
               if (pg_s) begin
                  rst_hold <= 1'b1;
                  state    <= ST_UP_CLK;
               end else if (pg_fire) begin
                  pwr_req <= 1'b0;
                  err     <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
            ST_UP_CLK: begin
               if (!pg_s) state <= ST_UN_CLK;
               else begin
                  clk_hold <= 1'b1;
                  state    <= ST_UP_W1;
               end
            end
            ST_UP_W1: begin
               if (!pg_s) state <= ST_UN_CLK;
               else if (wait_fire) begin
                  iso_clamp <= 1'b0;
                  state     <= ST_UP_W2;
               end
            end
            ST_UP_W2: begin
               if (!pg_s) state <= ST_UN_CLK;
               else if (wait_fire) begin
                  rst_hold <= 1'b0;
                  state    <= ST_UP_FLUSH;
               end
            end
            ST_UP_FLUSH: begin
               if (!pg_s) state <= ST_UN_CLK;
               else begin
                  flush_req <= 1'b0;
                  state     <= ST_UP_COFF;
               end
            end
            ST_UP_COFF: begin
               if (!pg_s) state <= ST_UN_CLK;
               else begin
                  clk_hold <= 1'b0;
                  done     <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            ST_PL_W1: begin
               if (wait_fire) begin
                  clk_hold <= 1'b1;
                  state    <= ST_PL_W2;
               end
            end
            ST_PL_W2: begin
               if (wait_fire) begin
                  rst_hold <= 1'b0;
                  state    <= ST_PL_COFF;
               end
            end
            ST_PL_COFF: begin
               clk_hold <= 1'b0;
               done     <= 1'b1;
               state    <= ST_IDLE;
            end
            ST_DN_CHK: begin
               if (|(ext_clk_on & clk_cap)) begin
                  rst_hold <= 1'b0;
                  err      <= 1'b1;
                  state    <= ST_IDLE;
               end else begin
                  flush_req <= 1'b1;
                  state     <= ST_DN_FLUSH;
               end
            end
            ST_DN_FLUSH: begin
               if (fa_s) begin
                  iso_clamp <= 1'b1;
                  state     <= ST_DN_OFF;
               end
            end
            ST_DN_OFF: begin
               pwr_req <= 1'b0;
               done    <= 1'b1;
               state   <= ST_IDLE;
            end
            ST_UN_CLK: begin
               clk_hold  <= 1'b0;
               rst_hold  <= 1'b1;
               flush_req <= 1'b1;
               state     <= ST_UN_CLAMP;
            end
            ST_UN_CLAMP: begin
               iso_clamp <= 1'b1;
               state     <= ST_UN_PWR;
            end
            ST_UN_PWR: begin
               pwr_req <= 1'b0;
               err     <= 1'b1;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pps_checker.sv
module pps_checker
   import pps_pkg::*;
#(
   parameter int NSLOT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2*NSLOT-1:0] slot_type,
   input logic               pwr_req,
   input logic               iso_clamp,
   input logic               flush_req,
   input logic               busy,
   input logic               done,
   input logic               err,
   input logic [NSLOT-1:0]   rst_out,
   input logic [NSLOT-1:0]   clk_en
);
   logic [NSLOT-1:0] m_rst_only, m_clk_only, m_rst_cap;

   always_comb begin
      for (int i = 0; i < NSLOT; i++) begin
         m_rst_only[i] = (slot_type[2*i +: 2] == 2'b10);
         m_clk_only[i] = (slot_type[2*i +: 2] == 2'b11);
         m_rst_cap[i]  = (slot_type[2*i +: 2] == 2'b01) || (slot_type[2*i +: 2] == 2'b10);
      end
   end

   p_rstonly_no_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en & m_rst_only) == '0);

   p_clkonly_no_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_out & m_clk_only) == '0);

   p_clamp_holds_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
      iso_clamp |-> (rst_out == m_rst_cap));

   p_unclamp_powered_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !iso_clamp |-> pwr_req);

   p_unpowered_no_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_req |-> (clk_en == '0));

   p_pwr_off_flushed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_req) |-> (flush_req && iso_clamp));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> !busy);
endmodule

bind pwr_part_seq pps_checker #(.NSLOT(NSLOT)) i_pps_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .slot_type (slot_type),
   .pwr_req   (pwr_req),
   .iso_clamp (iso_clamp),
   .flush_req (flush_req),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .rst_out   (rst_out),
   .clk_en    (clk_en)
);

// File: tb/test_pwr_part_seq.sv
module test_pwr_part_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NSLOT      = 4;
   localparam int CLK_MHZ    = 2;
   localparam int WAIT_US    = 3;
   localparam int LEN        = CLK_MHZ * WAIT_US;
   localparam int PG_TO      = 20;

   logic               clk, rst_n, cmd_valid, cmd_up, pwr_good, flush_ack;
   logic [2*NSLOT-1:0] slot_type;
   logic [NSLOT-1:0]   ext_clk_on, rst_out, clk_en;
   logic               pwr_req, iso_clamp, flush_req, busy, done, err;

   pwr_part_seq #(
      .NSLOT(NSLOT), .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US),
      .PG_TIMEOUT(PG_TO), .SYNC_IN(1'b0)
   ) i_pwr_part_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_up(cmd_up),
      .pwr_good(pwr_good), .flush_ack(flush_ack), .slot_type(slot_type),
      .ext_clk_on(ext_clk_on), .pwr_req(pwr_req), .rst_out(rst_out),
      .clk_en(clk_en), .iso_clamp(iso_clamp), .flush_req(flush_req),
      .busy(busy), .done(done), .err(err)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   int pg_delay = 3, fa_delay = 1, pg_cnt = 0, fa_cnt = 0;
   bit pg_dead = 0, pg_drop = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [NSLOT-1:0] cmask(input logic [2*NSLOT-1:0] t);
      logic [NSLOT-1:0] m;
      for (int i = 0; i < NSLOT; i++) m[i] = (t[2*i +: 2] == 2'b01) || (t[2*i +: 2] == 2'b11);
      return m;
   endfunction

   function automatic logic [NSLOT-1:0] rmask(input logic [2*NSLOT-1:0] t);
      logic [NSLOT-1:0] m;
      for (int i = 0; i < NSLOT; i++) m[i] = (t[2*i +: 2] == 2'b01) || (t[2*i +: 2] == 2'b10);
      return m;
   endfunction

   // one cycle: step to the falling edge, then update the switch and flush models
   task automatic tick();
      @(negedge clk);
      if (!pwr_req || pg_dead || pg_drop) begin
         pwr_good = 1'b0; pg_cnt = 0;
      end else if (pg_cnt >= pg_delay) pwr_good = 1'b1;
      else pg_cnt++;
      if (flush_req) begin
         if (fa_cnt >= fa_delay) flush_ack = 1'b1;
         else fa_cnt++;
      end else begin
         flush_ack = 1'b0; fa_cnt = 0;
      end
   endtask

   task automatic send(input logic up);
      cmd_valid = 1'b1; cmd_up = up;
      tick();
      cmd_valid = 1'b0;
   endtask

   // mode 0 normal, 1 with a command while busy, 2 with power lost after unclamp
   task automatic run_up(input int mode);
      logic [NSLOT-1:0] cm, rm;
      int t_clk = -1, t_unc = -1, t_rrel = -1, t_fl = -1, t_done = -1, t_err = -1, t_drop = -1;
      logic e_pwr = 1'b1, e_clamp = 1'b0, e_flush = 1'b0;
      logic [NSLOT-1:0] e_clk = '1, e_rst = '0;
      cm = cmask(slot_type); rm = rmask(slot_type);
      send(1'b1);
      chk(pwr_req == 1'b1, "R1", "power request after up", int'(pwr_req), 1);
      for (int k = 1; k < 400; k++) begin
         if (t_clk < 0 && clk_en != 0) begin
            t_clk = k;
            chk(clk_en == cm, "R2", "clock enables by type", int'(clk_en), int'(cm));
            chk(rst_out == rm, "R2", "resets by type", int'(rst_out), int'(rm));
            chk(iso_clamp == 1'b1, "R1", "clamp held at clock on", int'(iso_clamp), 1);
         end
         if (t_unc < 0 && iso_clamp == 1'b0) t_unc = k;
         if (t_unc >= 0 && t_rrel < 0 && rst_out == 0) t_rrel = k;
         if (t_fl < 0 && flush_req == 1'b0) t_fl = k;
         if (done && t_done < 0) begin
            t_done = k;
            chk(clk_en == 0, "R1", "clocks off at done", int'(clk_en), 0);
         end
         if (err && t_err < 0) begin
            t_err = k; e_pwr = pwr_req; e_clamp = iso_clamp; e_flush = flush_req;
            e_clk = clk_en; e_rst = rst_out;
         end
         if (t_done >= 0 || t_err >= 0) break;
         if (mode == 2 && t_unc >= 0 && t_drop < 0) begin pg_drop = 1; t_drop = k; end
         if (mode == 1 && k == 4) begin cmd_valid = 1'b1; cmd_up = 1'b0; end
         else cmd_valid = 1'b0;
         tick();
      end
      cmd_valid = 1'b0;
      if (mode != 2) begin
         chk(t_done > 0 && t_err < 0, "R1", "up completes without error", t_done, 1);
         chk(t_unc - t_clk == LEN, "R1", "clock-on to unclamp gap", t_unc - t_clk, LEN);
         chk(t_rrel - t_unc == LEN, "R1", "unclamp to reset release gap", t_rrel - t_unc, LEN);
         chk(t_fl - t_rrel == 1, "R1", "reset release to flush end", t_fl - t_rrel, 1);
         chk(t_done - t_fl == 1, "R1", "flush end to done", t_done - t_fl, 1);
         chk(pwr_req && !iso_clamp && busy == 1'b0, "R8", "powered and idle after up",
             int'({pwr_req, iso_clamp, busy}), 4);
         for (int j = 0; j < 3; j++) begin
            tick();
            chk(!done && !err, "R9", "no further pulse after done", int'({done, err}), 0);
            chk(pwr_req == 1'b1, "R8", "ignored command left power on", int'(pwr_req), 1);
         end
      end else begin
         chk(t_err > 0 && t_err - t_drop <= 8, "R7", "error after power loss", t_err - t_drop, 5);
         chk(!e_pwr && e_clamp && e_flush, "R7", "unpowered, clamped, flushing at error",
             int'({e_pwr, e_clamp, e_flush}), 3);
         chk(e_clk == 0, "R7", "clocks off after undo", int'(e_clk), 0);
         chk(e_rst == rm, "R7", "resets held after undo", int'(e_rst), int'(rm));
         pg_drop = 0;
         tick();
      end
   endtask

   task automatic run_pulse();
      logic [NSLOT-1:0] cm, rm;
      int t_clk = -1, t_rrel = -1, t_done = -1;
      bit bad = 0;
      cm = cmask(slot_type); rm = rmask(slot_type);
      send(1'b1);
      chk(rst_out == rm && clk_en == 0, "R3", "reset asserted, clocks off", int'(rst_out), int'(rm));
      for (int k = 1; k < 200; k++) begin
         if (iso_clamp || !pwr_req) bad = 1;
         if (t_clk < 0 && clk_en != 0) begin
            t_clk = k;
            chk(clk_en == cm, "R3", "pulse clocks by type", int'(clk_en), int'(cm));
         end
         if (t_rrel < 0 && rst_out == 0) t_rrel = k;
         if (done) begin t_done = k; break; end
         tick();
      end
      chk(t_clk == 1 + LEN, "R3", "clock on time", t_clk, 1 + LEN);
      chk(t_rrel == 1 + 2*LEN, "R3", "reset release time", t_rrel, 1 + 2*LEN);
      chk(t_done == 2 + 2*LEN, "R3", "pulse done time", t_done, 2 + 2*LEN);
      chk(!bad, "R3", "power kept and clamp open", int'(bad), 0);
      tick();
   endtask

   task automatic run_down();
      logic [NSLOT-1:0] cm, rm;
      bit conflict;
      int t_ack = -1, t_clampon = -1, t_off = -1, t_done = -1;
      cm = cmask(slot_type); rm = rmask(slot_type);
      conflict = |(ext_clk_on & cm);
      send(1'b0);
      chk(rst_out == rm, "R4", "resets asserted first", int'(rst_out), int'(rm));
      if (conflict) begin
         tick();
         chk(err == 1'b1, "R5", "refusal error", int'(err), 1);
         chk(rst_out == 0, "R5", "resets released on refusal", int'(rst_out), 0);
         chk(pwr_req && !iso_clamp, "R5", "power and clamp kept", int'({pwr_req, iso_clamp}), 2);
      end else begin
         for (int k = 1; k < 200; k++) begin
            if (k == 2) chk(flush_req == 1'b1, "R4", "flush requested", int'(flush_req), 1);
            if (t_ack < 0 && flush_ack && k >= 2) t_ack = k;
            if (t_clampon < 0 && iso_clamp) t_clampon = k;
            if (t_off < 0 && !pwr_req) t_off = k;
            if (done) begin t_done = k; break; end
            if (err) break;
            tick();
         end
         chk(t_clampon == t_ack + 1, "R4", "clamp after flush ack", t_clampon, t_ack + 1);
         chk(t_off == t_clampon + 1, "R4", "power off after clamp", t_off, t_clampon + 1);
         chk(t_done == t_off, "R4", "done with power off", t_done, t_off);
         chk(clk_en == 0 && rst_out == rm, "R4", "off state outputs", int'(clk_en), 0);
      end
      tick();
   endtask

   task automatic randomize_cfg();
      slot_type[1:0] = 2'b01;
      for (int i = 1; i < NSLOT; i++) slot_type[2*i +: 2] = 2'($urandom % 4);
      pg_delay = 2 + int'($urandom % 5);
      fa_delay = int'($urandom % 4);
      ext_clk_on = '0;
   endtask

   initial begin
      int t_err;
      void'($urandom(32'h5eed_0042));
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_up = 1'b0; pwr_good = 1'b0; flush_ack = 1'b0;
      slot_type = 8'b10_11_00_01; ext_clk_on = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R10 reset state
      chk(!pwr_req && iso_clamp && flush_req, "R10", "reset power/clamp/flush",
          int'({pwr_req, iso_clamp, flush_req}), 3);
      chk(clk_en == 0 && !busy, "R10", "reset clocks off, idle", int'(clk_en), 0);
      chk(rst_out == rmask(slot_type), "R10", "reset held on capable slots",
          int'(rst_out), int'(rmask(slot_type)));

      // R9 down while unpowered
      send(1'b0);
      chk(done && !err && !pwr_req && !busy, "R9", "down when off answers done",
          int'({done, err, pwr_req, busy}), 8);
      tick();
      chk(!done, "R9", "done is one cycle", int'(done), 0);

      for (int it = 0; it < 6; it++) begin
         randomize_cfg();
         run_up(0);
         run_pulse();
         ext_clk_on = NSLOT'($urandom);
         if (it % 2 == 0) ext_clk_on[0] = 1'b1;
         run_down();
         if (pwr_req) begin
            ext_clk_on = '0;
            run_down();
         end
      end

      // R6 power-good timeout
      randomize_cfg();
      pg_dead = 1;
      send(1'b1);
      t_err = -1;
      for (int k = 1; k < 100; k++) begin
         if (err) begin
            t_err = k;
            chk(!pwr_req && iso_clamp, "R6", "unpowered and clamped at timeout",
                int'({pwr_req, iso_clamp}), 1);
            break;
         end
         tick();
      end
      chk(t_err == PG_TO + 1, "R6", "timeout error time", t_err, PG_TO + 1);
      pg_dead = 0;
      tick();

      // R8 command while busy, then down
      randomize_cfg();
      run_up(1);
      run_down();

      // R7 power loss mid-sequence, then recovery
      randomize_cfg();
      run_up(2);
      run_up(0);
      run_down();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule